// File: doc/BRIEF.md
# Vector Lane Broadcast Unit

This block fills a 128-bit vector result with copies of one scalar element. It has two source modes. In scalar mode, the element comes from a 32-bit general-purpose value. Two select bits set the element size to 8, 16 or 32 bits. In vector mode, the element is one 32-bit half of a 64-bit vector source, and an index bit chooses which half. That word is copied into all four 32-bit lanes.

Requests enter on a valid/ready stream, and results leave on another. A request is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. Its result appears registered on the next cycle, with `out_valid` high. The output holds one result. `in_ready` is high when that slot is empty, or when the consumer takes the current result in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the block stalls: `in_ready` stays low and `out_data` does not change. Lane 0 sits in the lowest bits of `out_data`, and higher lanes follow in ascending bit order.

Top module: `lane_bcast`

## Requirements
- R1: In scalar mode (`mode_vec`=0) with `sel_h16`=1, every 16-bit lane of the result equals `scalar_in[15:0]`, whatever the value of `sel_b8`.
- R2: In scalar mode with `sel_h16`=0 and `sel_b8`=1, every one of the 16 byte lanes equals `scalar_in[7:0]`.
- R3: In scalar mode with both select bits at 0, every one of the four 32-bit lanes equals `scalar_in`.
- R4: In vector mode (`mode_vec`=1), every 32-bit lane equals `vsrc_in[31:0]` when `word_idx`=0 and `vsrc_in[63:32]` when `word_idx`=1. Both select bits have no effect in this mode.
- R5: After a request is accepted, `out_valid` is high on the following cycle, and `out_data` holds that request's result.
- R6: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0. On the next cycle `out_valid` stays 1 and `out_data` is unchanged, even if `in_valid` is high.
- R7: A synchronous active-high `rst` clears `out_valid` and `out_data` to zero on the following edge.
- R8: When the consumer takes a result and no new request is accepted on that edge, `out_valid` falls and `out_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted this cycle |
| mode_vec | input | 1 | 0: scalar source, 1: half of vector source |
| sel_h16 | input | 1 | Selects 16-bit elements in scalar mode; takes priority over sel_b8 |
| sel_b8 | input | 1 | Selects 8-bit elements in scalar mode when sel_h16 is 0 |
| scalar_in | input | 32 | Scalar source value |
| vsrc_in | input | 64 | 64-bit vector source |
| word_idx | input | 1 | Vector mode: 0 picks the low word, 1 picks the high word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Broadcast result |

## Verification
The bench sweeps many scalar and vector patterns through every combination of the two select bits, in both modes and with both index values. It computes each expected vector with shift arithmetic. The sweep catches a decoder that gives `sel_b8` priority over `sel_h16`, which would return byte lanes where 16-bit lanes are expected. It also catches a design that forgets to truncate the scalar, or that lets the select bits leak into vector mode. Patterns whose upper and lower halves differ catch a design that swaps the index sense. A stall is held with a competing request waiting, which catches a design that overwrites the held result or drops the waiting request. The drain and mid-run reset tests catch a valid flag that sticks high and data that is cleared when it should be kept.

// File: rtl/lane_bcast_pkg.sv
package lane_bcast_pkg;
  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2
  } elem_size_e;
endpackage

// File: rtl/lane_bcast_size_dec.sv
module lane_bcast_size_dec
  import lane_bcast_pkg::*;
(
  input  logic       mode_vec,
  input  logic       sel_h16,
  input  logic       sel_b8,
  output elem_size_e elem_size
);
  // Vector mode always yields word lanes; sel_h16 outranks sel_b8.
  always_comb begin
    if (mode_vec)      elem_size = ESZ_32;
    else if (sel_h16)  elem_size = ESZ_16;
    else if (sel_b8)   elem_size = ESZ_8;
    else               elem_size = ESZ_32;
  end
endmodule

// File: rtl/lane_bcast_word_pick.sv
module lane_bcast_word_pick #(
  parameter int WORD_W = 32,
  localparam int SRC_W = 2 * WORD_W
) (
  input  logic              mode_vec,
  input  logic [WORD_W-1:0] scalar_in,
  input  logic [SRC_W-1:0]  vsrc_in,
  input  logic              word_idx,
  output logic [WORD_W-1:0] word_out
);
  logic [WORD_W-1:0] half_sel;

  always_comb begin
    half_sel = word_idx ? vsrc_in[SRC_W-1:WORD_W] : vsrc_in[WORD_W-1:0];
    word_out = mode_vec ? half_sel : scalar_in;
  end
endmodule

// File: rtl/lane_bcast_replicate.sv
module lane_bcast_replicate
  import lane_bcast_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word_in,
  input  elem_size_e        elem_size,
  output logic [VEC_W-1:0]  vec_out
);
  localparam int N8  = VEC_W / 8;
  localparam int N16 = VEC_W / 16;
  localparam int N32 = VEC_W / WORD_W;

  logic [VEC_W-1:0] rep8, rep16, rep32;

  for (genvar g = 0; g < N8; g++) begin : g_b8
    assign rep8[g*8 +: 8] = word_in[7:0];
  end
  for (genvar g = 0; g < N16; g++) begin : g_h16
    assign rep16[g*16 +: 16] = word_in[15:0];
  end
  for (genvar g = 0; g < N32; g++) begin : g_w32
    assign rep32[g*WORD_W +: WORD_W] = word_in;
  end

  always_comb begin
    case (elem_size)
      ESZ_8:   vec_out = rep8;
      ESZ_16:  vec_out = rep16;
      default: vec_out = rep32;
    endcase
  end
endmodule

// File: rtl/lane_bcast_out_stage.sv
module lane_bcast_out_stage #(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lane_bcast.sv
module lane_bcast
  import lane_bcast_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int WORD_W = 32,
  localparam int SRC_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              mode_vec,
  input  logic              sel_h16,
  input  logic              sel_b8,
  input  logic [WORD_W-1:0] scalar_in,
  input  logic [SRC_W-1:0]  vsrc_in,
  input  logic              word_idx,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VEC_W-1:0]  out_data
);
  elem_size_e        elem_size;
  logic [WORD_W-1:0] word;
  logic [VEC_W-1:0]  bcast;

  lane_bcast_size_dec u_dec (
    .mode_vec (mode_vec),
    .sel_h16  (sel_h16),
    .sel_b8   (sel_b8),
    .elem_size(elem_size)
  );

  lane_bcast_word_pick #(.WORD_W(WORD_W)) u_pick (
    .mode_vec (mode_vec),
    .scalar_in(scalar_in),
    .vsrc_in  (vsrc_in),
    .word_idx (word_idx),
    .word_out (word)
  );

  lane_bcast_replicate #(.VEC_W(VEC_W), .WORD_W(WORD_W)) u_rep (
    .word_in  (word),
    .elem_size(elem_size),
    .vec_out  (bcast)
  );

  lane_bcast_out_stage #(.DATA_W(VEC_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (bcast),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
  );
endmodule

// File: rtl/lane_bcast_chk.sv
module lane_bcast_chk #(
  parameter int VEC_W  = 128,
  parameter int WORD_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic               mode_vec,
  input logic               sel_h16,
  input logic [WORD_W-1:0]  scalar_in,
  input logic [2*WORD_W-1:0] vsrc_in,
  input logic               word_idx,
  input logic               out_valid,
  input logic               out_ready,
  input logic [VEC_W-1:0]   out_data
);
  // R1
  half_lane_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && !mode_vec && sel_h16 |=>
      out_data[15:0] == $past(scalar_in[15:0]) &&
      out_data[VEC_W-1 -: 16] == $past(scalar_in[15:0]));

  // R4
  vec_word_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && mode_vec |=>
      out_data[WORD_W-1:0] == ($past(word_idx) ? $past(vsrc_in[2*WORD_W-1:WORD_W])
                                               : $past(vsrc_in[WORD_W-1:0])) &&
      out_data[VEC_W-1 -: WORD_W] == out_data[WORD_W-1:0]);

  // R5
  accept_valid_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  // R6
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !out_valid && out_data == '0);

  // R8
  drain_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !in_valid |=> !out_valid && $stable(out_data));
endmodule

bind lane_bcast lane_bcast_chk #(.VEC_W(VEC_W), .WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .mode_vec (mode_vec),
  .sel_h16  (sel_h16),
  .scalar_in(scalar_in),
  .vsrc_in  (vsrc_in),
  .word_idx (word_idx),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data)
);

// File: tb/lane_bcast_test.sv
module lane_bcast_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         in_ready;
  logic         mode_vec;
  logic         sel_h16;
  logic         sel_b8;
  logic [31:0]  scalar_in;
  logic [63:0]  vsrc_in;
  logic         word_idx;
  logic         out_valid;
  logic         out_ready;
  logic [127:0] out_data;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_bcast uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .mode_vec(mode_vec), .sel_h16(sel_h16), .sel_b8(sel_b8),
    .scalar_in(scalar_in), .vsrc_in(vsrc_in), .word_idx(word_idx),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [127:0] model(input logic vm, input logic h, input logic b,
                                         input logic [31:0] s, input logic [63:0] v,
                                         input logic ix);
    logic [127:0] r = '0;
    logic [31:0]  w;
    int           ew;
    if (vm) begin
      w  = ix ? v[63:32] : v[31:0];
      ew = 32;
    end else if (h) begin
      w  = {16'd0, s[15:0]};
      ew = 16;
    end else if (b) begin
      w  = {24'd0, s[7:0]};
      ew = 8;
    end else begin
      w  = s;
      ew = 32;
    end
    for (int i = 0; i < 128 / ew; i++) r = r | ({96'd0, w} << (i * ew));
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [127:0] exp_a, exp_b;
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    mode_vec = 1'b0; sel_h16 = 1'b0; sel_b8 = 1'b0;
    scalar_in = '0; vsrc_in = '0; word_idx = 1'b0;
    repeat (3) @(negedge clk);
    // R7 reset state
    check("R7 valid after reset", {127'd0, out_valid}, 128'd0);
    check("R7 data after reset", out_data, 128'd0);
    rst = 1'b0;

    // Sweep: patterns x select combos x modes x index (R1..R5)
    for (int p = 0; p < 48; p++) begin
      for (int c = 0; c < 16; c++) begin
        logic [127:0] e;
        @(negedge clk);
        scalar_in = 32'h9E37_79B1 * (p + 1) ^ (32'h0101_0101 << (p % 8));
        vsrc_in   = {32'hC2B2_AE35 * (p + 3), 32'h85EB_CA6B * (p + 7)};
        mode_vec  = c[3];
        word_idx  = c[2];
        sel_h16   = c[1];
        sel_b8    = c[0];
        in_valid  = 1'b1;
        check("R5 ready when empty", {127'd0, in_ready}, 128'd1);
        e = model(mode_vec, sel_h16, sel_b8, scalar_in, vsrc_in, word_idx);
        @(negedge clk);
        check("R5 valid one cycle later", {127'd0, out_valid}, 128'd1);
        if (mode_vec)          check("R4 vector half broadcast", out_data, e);
        else if (sel_h16)      check("R1 16-bit broadcast", out_data, e);
        else if (sel_b8)       check("R2 8-bit broadcast", out_data, e);
        else                   check("R3 32-bit broadcast", out_data, e);
        in_valid = 1'b0;
      end
    end

    // Stall: present A, hold consumer, offer B (R6)
    @(negedge clk);
    mode_vec = 1'b0; sel_h16 = 1'b0; sel_b8 = 1'b1; scalar_in = 32'hAABB_CC5A;
    in_valid = 1'b1; out_ready = 1'b0;
    exp_a = {16{8'h5A}};
    @(negedge clk);
    check("R5 stall entry data", out_data, exp_a);
    sel_h16 = 1'b1; scalar_in = 32'h1234_F00D;
    exp_b = {8{16'hF00D}};
    for (int k = 0; k < 4; k++) begin
      check("R6 ready low in stall", {127'd0, in_ready}, 128'd0);
      @(negedge clk);
      check("R6 valid held", {127'd0, out_valid}, 128'd1);
      check("R6 data held", out_data, exp_a);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check("R6 waiting request taken after release", out_data, exp_b);
    in_valid = 1'b0;
    @(negedge clk);
    // R8 drain keeps data
    check("R8 valid drops", {127'd0, out_valid}, 128'd0);
    check("R8 data kept", out_data, exp_b);
    @(negedge clk);
    check("R8 data still kept", out_data, exp_b);

    // Mid-run reset (R7)
    in_valid = 1'b1; mode_vec = 1'b1; word_idx = 1'b1; vsrc_in = 64'hDEAD_BEEF_0000_0001;
    @(negedge clk);
    check("R4 high word", out_data, {4{32'hDEAD_BEEF}});
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R7 valid cleared", {127'd0, out_valid}, 128'd0);
    check("R7 data cleared", out_data, 128'd0);
    rst = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule